// File: doc/BRIEF.md
# Byte-Framed Serial ADC Readout Host

This block is the host side of a three-wire serial link to a 12-bit successive-approximation converter with two analog inputs. A single request carries a channel choice (the input-mode bit and the channel/polarity bit). The block then runs one complete readout. It lowers chip select and produces 24 serial clock cycles, built as three 8-bit transfers, from the system clock through a divider. It shifts the command out, collects the converter's reply, raises chip select, and presents the 12-bit code together with a one-cycle done pulse.

The converter needs only 17 serial clocks. The frame is padded in front with seven zeros, so the reply ends exactly on the last clock of the third byte and the code sits right-aligned in the final twelve sampled bits. The converter's low null bit arrives on the clock just before the code. The block checks it and raises an error flag if it reads high.

The serial clock's resting level is chosen by a parameter. In both settings the host drives the command line while the serial clock is low and samples the reply when the clock goes high. The CS setup time, the half-period length and the minimum CS high time between frames are parameters counted in system clocks. These parameters must be chosen to meet the converter's clock-rate ceiling and minimum clock rate for the system clock in use.

Top module: `adc_byte_host`

## Requirements
- R1: The command line carries 24 bits per frame, first bit first. Bits 0 to 6 are 0 and bit 7 is the start bit 1. Bit 8 is `req_single` (1 = single-ended, 0 = pseudo-differential). Bit 9 is `req_odd` (channel 1 when single-ended; with 0 = input 0 positive when differential). Bit 10 (bit-order select) is 0 and bits 11 to 23 are 0. `spi_mosi` changes only while `spi_sclk` is low.
- R2: Each of the 24 bits is DIV_HALF system clocks with `spi_sclk` low followed by DIV_HALF clocks with it high, giving exactly 24 rising edges per frame. With CPOL=0, `spi_sclk` rests low whenever `spi_cs_n` is high. `spi_cs_n` stays low for CS_SETUP+48*DIV_HALF cycles.
- R3: A request accepted at a clock edge drives `spi_cs_n` low right after that edge. The first rising `spi_sclk` follows CS_SETUP+DIV_HALF cycles after that edge.
- R4: `result` equals the `spi_miso` values sampled at rising edges 13 to 24, with the first of them as the most significant bit.
- R5: `null_err` is the `spi_miso` value sampled at rising edge 12 (the null bit). A 1 there flags an error, and `result` is still updated.
- R6: `done` is high for exactly one cycle, the first cycle after `spi_cs_n` returns high. `result` and `null_err` change only in that cycle.
- R7: `busy` is high from the accepting edge until CS_GAP cycles after `spi_cs_n` rises. `spi_cs_n` then stays high at least CS_GAP cycles. With a request held high, the next frame lowers `spi_cs_n` CS_GAP+1 cycles after it rose.
- R8: A request presented while `busy` is high is ignored. It starts no frame and alters neither the command bits nor the result of the running frame.
- R9: With CPOL=1, `spi_sclk` rests high while `spi_cs_n` is high and falls at the start of bit 0. Rise timing, sampling and results match CPOL=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a readout (taken when idle) |
| req_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| req_odd | input | 1 | Channel select / differential polarity |
| busy | output | 1 | Frame or CS-high gap in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Converted code, straight binary |
| null_err | output | 1 | Null bit read as 1 in the last frame |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Command bits to converter |
| spi_miso | input | 1 | Reply bits from converter |

## Verification
Cycle counts are taken from the edge that accepts a request. With the defaults (DIV_HALF=4, CS_SETUP=3, CS_GAP=6), the first high `spi_sclk` is due 7 cycles later and `spi_cs_n` rises after 195 cycles. `done` with the new `result` follows at 196, and `busy` falls at 201. Each scenario samples the outputs on the falling system clock edge, so it reads the values settled after edge j. It records the exact index at which each event first appears and compares that index with these figures, not with a window. A behavioural converter model replies on falling serial edges and records the 24 command bits on rising ones. Reply codes, the command frame and the null-bit fault are therefore computed by the bench from the requirements.

// File: rtl/ahost_pkg.sv
package ahost_pkg;
   localparam int FRAME_BITS = 24;
   localparam int BIT_W      = $clog2(FRAME_BITS);
   localparam int START_POS  = 7;
   localparam int MODE_POS   = 8;
   localparam int POL_POS    = 9;
   localparam int ORDER_POS  = 10;
   localparam int NULL_POS   = 11;
   localparam int RES_W      = 12;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_SHIFT = 3'd2,
      ST_FIN   = 3'd3,
      ST_GAP   = 3'd4
   } ahost_state_e;

   typedef struct packed {
      logic single;
      logic odd;
   } ahost_cfg_t;

   // Command bit for a given position in the padded frame.
   function automatic logic frame_bit(ahost_cfg_t c, logic [BIT_W-1:0] idx);
      logic b;
      b = 1'b0;
      if (idx == BIT_W'(START_POS)) b = 1'b1;
      else if (idx == BIT_W'(MODE_POS)) b = c.single;
      else if (idx == BIT_W'(POL_POS)) b = c.odd;
      else if (idx == BIT_W'(ORDER_POS)) b = 1'b0;
      return b;
   endfunction
endpackage

// File: rtl/ahost_seq.sv
module ahost_seq
   import ahost_pkg::*;
#(
   parameter int DIV_HALF = 4,
   parameter int CS_SETUP = 3,
   parameter int CS_GAP   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  ahost_cfg_t           req_cfg,
   output ahost_state_e         state,
   output logic                 phase_hi,
   output logic [BIT_W-1:0]     bit_idx,
   output ahost_cfg_t           cfg_q,
   output logic                 sample_stb,
   output logic                 commit,
   output logic                 busy
);
   localparam int MAX_A   = (DIV_HALF > CS_SETUP) ? DIV_HALF : CS_SETUP;
   localparam int CNT_MAX = (MAX_A > CS_GAP) ? MAX_A : CS_GAP;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0] cnt;
   logic             half_end;
   logic             last_bit;

   assign half_end   = (state == ST_SHIFT) && (cnt == CNT_W'(DIV_HALF - 1));
   assign last_bit   = (bit_idx == BIT_W'(FRAME_BITS - 1));
   assign sample_stb = half_end && !phase_hi;
   assign commit     = (state == ST_FIN);
   assign busy       = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         phase_hi <= 1'b0;
         bit_idx  <= '0;
         cfg_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state <= ST_SETUP;
                  cnt   <= '0;
                  cfg_q <= req_cfg;
               end
            end
            ST_SETUP: begin
               if (cnt == CNT_W'(CS_SETUP - 1)) begin
                  state    <= ST_SHIFT;
                  cnt      <= '0;
                  phase_hi <= 1'b0;
                  bit_idx  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (half_end) begin
                  cnt <= '0;
                  if (!phase_hi) begin
                     phase_hi <= 1'b1;
                  end else begin
                     phase_hi <= 1'b0;
                     if (last_bit) state <= ST_FIN;
                     else bit_idx <= bit_idx + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_FIN: begin
               state <= ST_GAP;
               cnt   <= CNT_W'(1);
            end
            ST_GAP: begin
               if (cnt == CNT_W'(CS_GAP - 1)) state <= ST_IDLE;
               else cnt <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ahost_pins.sv
module ahost_pins
   import ahost_pkg::*;
#(
   parameter int CPOL = 0
) (
   input  ahost_state_e     state,
   input  logic             phase_hi,
   input  logic [BIT_W-1:0] bit_idx,
   input  ahost_cfg_t       cfg_q,
   output logic             spi_cs_n,
   output logic             spi_sclk,
   output logic             spi_mosi
);
   logic shifting;

   assign shifting = (state == ST_SHIFT);
   assign spi_cs_n = !((state == ST_SETUP) || shifting);
   assign spi_mosi = shifting ? frame_bit(cfg_q, bit_idx) : 1'b0;

   generate
      if (CPOL == 0) begin : g_rest_low
         assign spi_sclk = shifting && phase_hi;
      end else begin : g_rest_high
         assign spi_sclk = shifting ? phase_hi : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/ahost_rx.sv
module ahost_rx
   import ahost_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_stb,
   input  logic [BIT_W-1:0] bit_idx,
   input  logic             spi_miso,
   input  logic             commit,
   output logic [RES_W-1:0] result,
   output logic             null_err,
   output logic             done
);
   logic [RES_W:0] sh;
   logic           in_window;

   assign in_window = (bit_idx >= BIT_W'(NULL_POS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         result   <= '0;
         null_err <= 1'b0;
         done     <= 1'b0;
      end else begin
         if (sample_stb && in_window) sh <= {sh[RES_W-1:0], spi_miso};
         done <= commit;
         if (commit) begin
            result   <= sh[RES_W-1:0];
            null_err <= sh[RES_W];
         end
      end
   end
endmodule

// File: rtl/adc_byte_host.sv
module adc_byte_host #(
   parameter int DIV_HALF = 4,
   parameter int CS_SETUP = 3,
   parameter int CS_GAP   = 6,
   parameter int CPOL     = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_single,
   input  logic                          req_odd,
   output logic                          busy,
   output logic                          done,
   output logic [ahost_pkg::RES_W-1:0]   result,
   output logic                          null_err,
   output logic                          spi_cs_n,
   output logic                          spi_sclk,
   output logic                          spi_mosi,
   input  logic                          spi_miso
);
   import ahost_pkg::*;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (CS_SETUP < 1) begin : g_bad_setup
         $error("CS_SETUP must be at least 1");
      end
      if (CS_GAP < 2) begin : g_bad_gap
         $error("CS_GAP must be at least 2");
      end
      if (CPOL != 0 && CPOL != 1) begin : g_bad_cpol
         $error("CPOL must be 0 or 1");
      end
      if (NULL_POS + RES_W + 1 != FRAME_BITS) begin : g_bad_frame
         $error("reply window does not end on the last frame bit");
      end
   endgenerate

   ahost_state_e      state;
   logic              phase_hi;
   logic [BIT_W-1:0]  bit_idx;
   ahost_cfg_t        req_cfg;
   ahost_cfg_t        cfg_q;
   logic              sample_stb;
   logic              commit;

   assign req_cfg = '{single: req_single, odd: req_odd};

   ahost_seq #(
      .DIV_HALF (DIV_HALF),
      .CS_SETUP (CS_SETUP),
      .CS_GAP   (CS_GAP)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_cfg    (req_cfg),
      .state      (state),
      .phase_hi   (phase_hi),
      .bit_idx    (bit_idx),
      .cfg_q      (cfg_q),
      .sample_stb (sample_stb),
      .commit     (commit),
      .busy       (busy)
   );

   ahost_pins #(
      .CPOL (CPOL)
   ) u_pins (
      .state    (state),
      .phase_hi (phase_hi),
      .bit_idx  (bit_idx),
      .cfg_q    (cfg_q),
      .spi_cs_n (spi_cs_n),
      .spi_sclk (spi_sclk),
      .spi_mosi (spi_mosi)
   );

   ahost_rx u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .bit_idx    (bit_idx),
      .spi_miso   (spi_miso),
      .commit     (commit),
      .result     (result),
      .null_err   (null_err),
      .done       (done)
   );
endmodule

// File: rtl/ahost_chk.sv
module ahost_chk #(
   parameter int CS_GAP     = 6,
   parameter int CPOL       = 0,
   parameter int FRAME_BITS = 24
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);
   localparam int HW = $clog2(CS_GAP + 2) + 1;
   localparam int RW = $clog2(FRAME_BITS + 1);

   logic [HW-1:0] hi_cnt;
   logic [RW-1:0] rise_cnt;
   logic          sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= HW'(CS_GAP + 1);
         rise_cnt <= '0;
         sclk_d   <= 1'(CPOL);
      end else begin
         sclk_d <= spi_sclk;
         if (spi_cs_n) begin
            rise_cnt <= '0;
            if (hi_cnt < HW'(CS_GAP + 1)) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
            if (spi_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
         end
      end
   end

   assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);
   assert_sclk_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> (spi_sclk == 1'(CPOL)));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && busy));
   assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && spi_sclk && $past(!spi_cs_n && spi_sclk)) |-> $stable(spi_mosi));
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !$fell(spi_cs_n));
   assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt >= HW'(CS_GAP)));
   assert_rise_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (rise_cnt == RW'(FRAME_BITS)));
endmodule

bind adc_byte_host ahost_chk #(
   .CS_GAP     (CS_GAP),
   .CPOL       (CPOL),
   .FRAME_BITS (ahost_pkg::FRAME_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .spi_cs_n (spi_cs_n),
   .spi_sclk (spi_sclk),
   .spi_mosi (spi_mosi)
);

// File: tb/sim_adc_byte_host.sv
module sim_adc_model (
   input  logic        cs_n,
   input  logic        sclk,
   input  logic        din,
   input  logic [47:0] codes,
   input  logic        bad_null,
   output logic        dout,
   output logic [23:0] din_word,
   output int          frames
);
   bit        dq = 1'b1;
   bit [23:0] dw;
   int        fr;
   int        seen;
   int        r;

   assign dout     = dq;
   assign din_word = dw;
   assign frames   = fr;

   always @(negedge cs_n) fr = fr + 1;

   always @(posedge sclk) begin
      if (!cs_n) begin
         if (seen != fr) begin
            seen = fr;
            r    = 0;
         end
         if (r < 24) dw[r] = din;
         r = r + 1;
      end
   end

   always @(negedge sclk) begin
      if (!cs_n) begin
         int sel;
         logic [11:0] c;
         sel = {30'd0, dw[8], dw[9]};
         c   = codes[sel*12 +: 12];
         if (r == 11) dq = bad_null;
         else if (r >= 12 && r <= 23) dq = c[23 - r];
         else dq = 1'b1;
      end
   end
endmodule

module sim_adc_byte_host;
   localparam int CLK_P = 10;
   localparam int DIV   = 4;
   localparam int SETUP = 3;
   localparam int GAP   = 6;
   localparam int E_HI   = SETUP + DIV;
   localparam int E_RISE = SETUP + 48 * DIV;
   localparam int E_DONE = E_RISE + 1;
   localparam int E_IDLE = E_RISE + GAP;

   logic clk = 1'b0;
   always #(CLK_P / 2) clk = ~clk;
   logic rst_n = 1'b0;

   logic req0 = 1'b0, sgl0 = 1'b0, odd0 = 1'b0;
   logic req1 = 1'b0, sgl1 = 1'b0, odd1 = 1'b0;
   logic busy0, done0, err0, cs0, sck0, mosi0, miso0;
   logic busy1, done1, err1, cs1, sck1, mosi1, miso1;
   logic [11:0] res0, res1;
   logic [47:0] codes = {12'hA5C, 12'h3E1, 12'h800, 12'h07F};
   logic bad_null = 1'b0;
   logic [23:0] dw0, dw1;
   int fr0, fr1;

   adc_byte_host #(.DIV_HALF(DIV), .CS_SETUP(SETUP), .CS_GAP(GAP), .CPOL(0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req0), .req_single(sgl0), .req_odd(odd0),
      .busy(busy0), .done(done0), .result(res0), .null_err(err0),
      .spi_cs_n(cs0), .spi_sclk(sck0), .spi_mosi(mosi0), .spi_miso(miso0));

   adc_byte_host #(.DIV_HALF(DIV), .CS_SETUP(SETUP), .CS_GAP(GAP), .CPOL(1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(req1), .req_single(sgl1), .req_odd(odd1),
      .busy(busy1), .done(done1), .result(res1), .null_err(err1),
      .spi_cs_n(cs1), .spi_sclk(sck1), .spi_mosi(mosi1), .spi_miso(miso1));

   sim_adc_model m0 (.cs_n(cs0), .sclk(sck0), .din(mosi0), .codes(codes),
      .bad_null(bad_null), .dout(miso0), .din_word(dw0), .frames(fr0));
   sim_adc_model m1 (.cs_n(cs1), .sclk(sck1), .din(mosi1), .codes(codes),
      .bad_null(bad_null), .dout(miso1), .din_word(dw1), .frames(fr1));

   int tests = 0;
   int fails = 0;

   int j_hi, hi_run, j_rise, j_done, n_done, j_idle;
   logic [11:0] r_res;
   logic r_err;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what,
                  $signed(act), $signed(exp));
      end
   endtask

   function automatic logic [11:0] exp_code(input logic s, input logic o);
      int sel;
      sel = {30'd0, s, o};
      return codes[sel*12 +: 12];
   endfunction

   function automatic logic [23:0] exp_frame(input logic s, input logic o);
      return 24'h000080 | ({23'd0, s} << 8) | ({23'd0, o} << 9);
   endfunction

   // One readout on instance `which`; records event indices j counted from the accepting edge.
   task automatic run_frame(input int which, input logic s, input logic o, input bit poke);
      logic prev, cs, sck, bz, dn, run_open;
      @(negedge clk);
      if (which == 0) begin req0 = 1'b1; sgl0 = s; odd0 = o; end
      else begin req1 = 1'b1; sgl1 = s; odd1 = o; end
      @(posedge clk);
      j_hi = -1; hi_run = 0; j_rise = -1; j_done = -1; n_done = 0; j_idle = -1;
      prev = 1'b1; run_open = 1'b0;
      for (int j = 0; j < 2000; j++) begin
         @(negedge clk);
         if (j == 0) begin req0 = 1'b0; req1 = 1'b0; end
         if (poke && j == 50) begin
            if (which == 0) begin req0 = 1'b1; sgl0 = !s; odd0 = !o; end
            else begin req1 = 1'b1; sgl1 = !s; odd1 = !o; end
         end
         if (poke && j == 51) begin
            req0 = 1'b0; req1 = 1'b0;
            sgl0 = s; odd0 = o; sgl1 = s; odd1 = o;
         end
         cs  = (which == 0) ? cs0 : cs1;
         sck = (which == 0) ? sck0 : sck1;
         bz  = (which == 0) ? busy0 : busy1;
         dn  = (which == 0) ? done0 : done1;
         if (!cs && sck && !prev && j_hi < 0) begin j_hi = j; run_open = 1'b1; end
         if (run_open) begin
            if (sck) hi_run++;
            else run_open = 1'b0;
         end
         if (cs && j_rise < 0 && j > 0) j_rise = j;
         if (dn) begin
            n_done++;
            if (j_done < 0) begin
               j_done = j;
               r_res  = (which == 0) ? res0 : res1;
               r_err  = (which == 0) ? err0 : err1;
            end
         end
         if (!bz && j > 0) begin j_idle = j; break; end
         prev = sck;
      end
   endtask

   task automatic t_reset();
      check("R2", "cs_n at reset", {31'd0, cs0}, 1);
      check("R2", "sclk rest low CPOL0", {31'd0, sck0}, 0);
      check("R9", "sclk rest high CPOL1", {31'd0, sck1}, 1);
      check("R7", "busy at reset", {31'd0, busy0}, 0);
      check("R6", "done at reset", {31'd0, done0}, 0);
   endtask

   task automatic t_timing_single0();
      int f0;
      f0 = fr0;
      run_frame(0, 1'b1, 1'b0, 1'b0);
      check("R1", "command frame", {8'd0, dw0}, {8'd0, exp_frame(1'b1, 1'b0)});
      check("R3", "first sclk high index", j_hi, E_HI);
      check("R2", "sclk high length", hi_run, DIV);
      check("R2", "cs_n rise index", j_rise, E_RISE);
      check("R6", "done index", j_done, E_DONE);
      check("R6", "done pulse count", n_done, 1);
      check("R7", "busy low index", j_idle, E_IDLE);
      check("R4", "result single ch0", {20'd0, r_res}, {20'd0, exp_code(1'b1, 1'b0)});
      check("R5", "null_err clear", {31'd0, r_err}, 0);
      check("R2", "one frame", fr0 - f0, 1);
   endtask

   task automatic t_channel(input logic s, input logic o);
      run_frame(0, s, o, 1'b0);
      check("R1", "command frame", {8'd0, dw0}, {8'd0, exp_frame(s, o)});
      check("R4", "result", {20'd0, r_res}, {20'd0, exp_code(s, o)});
      check("R6", "result held after done", {20'd0, res0}, {20'd0, exp_code(s, o)});
   endtask

   task automatic t_extremes();
      codes = {12'h000, 12'hFFF, 12'h800, 12'h07F};
      run_frame(0, 1'b1, 1'b0, 1'b0);
      check("R4", "full-scale code", {20'd0, r_res}, 32'hFFF);
      run_frame(0, 1'b1, 1'b1, 1'b0);
      check("R4", "zero code", {20'd0, r_res}, 32'h000);
      codes = {12'hA5C, 12'h3E1, 12'h800, 12'h07F};
   endtask

   task automatic t_bad_null();
      bad_null = 1'b1;
      run_frame(0, 1'b0, 1'b1, 1'b0);
      bad_null = 1'b0;
      check("R5", "null_err set", {31'd0, r_err}, 1);
      check("R5", "result still updated", {20'd0, r_res}, {20'd0, exp_code(1'b0, 1'b1)});
      run_frame(0, 1'b0, 1'b0, 1'b0);
      check("R5", "null_err cleared next frame", {31'd0, r_err}, 0);
   endtask

   task automatic t_busy_ignore();
      int f0;
      f0 = fr0;
      run_frame(0, 1'b1, 1'b1, 1'b1);
      check("R8", "command unchanged by poke", {8'd0, dw0}, {8'd0, exp_frame(1'b1, 1'b1)});
      check("R8", "result of first request", {20'd0, r_res}, {20'd0, exp_code(1'b1, 1'b1)});
      repeat (5) @(negedge clk);
      check("R8", "no extra frame", fr0 - f0, 1);
      check("R8", "cs_n high after frame", {31'd0, cs0}, 1);
   endtask

   task automatic t_gap();
      int gap;
      int stage;
      @(negedge clk);
      req0 = 1'b1; sgl0 = 1'b1; odd0 = 1'b0;
      gap = 0; stage = 0;
      for (int k = 0; k < 3000 && stage < 3; k++) begin
         @(negedge clk);
         if (stage == 0 && !cs0) stage = 1;
         else if (stage == 1 && cs0) begin stage = 2; gap = 1; end
         else if (stage == 2) begin
            if (cs0) gap++;
            else stage = 3;
         end
      end
      req0 = 1'b0;
      check("R7", "cs_n high gap with held request", gap, GAP + 1);
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (!busy0) break;
      end
      check("R4", "second back-to-back result", {20'd0, res0}, {20'd0, exp_code(1'b1, 1'b0)});
   endtask

   task automatic t_mode_high();
      run_frame(1, 1'b0, 1'b1, 1'b0);
      check("R9", "command frame CPOL1", {8'd0, dw1}, {8'd0, exp_frame(1'b0, 1'b1)});
      check("R9", "first sclk high index CPOL1", j_hi, E_HI);
      check("R9", "sclk high length CPOL1", hi_run, DIV);
      check("R9", "done index CPOL1", j_done, E_DONE);
      check("R9", "result CPOL1", {20'd0, r_res}, {20'd0, exp_code(1'b0, 1'b1)});
      check("R9", "sclk rests high after frame", {31'd0, sck1}, 1);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_timing_single0();
      t_channel(1'b1, 1'b1);
      t_channel(1'b0, 1'b0);
      t_channel(1'b0, 1'b1);
      t_extremes();
      t_bad_null();
      t_busy_ignore();
      t_gap();
      t_mode_high();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule